// File: doc/BRIEF.md
# Prioritized Interrupt Controller Bank

This block gathers up to 32 interrupt request lines into one bank, records them in a pending register, filters them through a mask, and selects a winner for each of two processor paths: a normal path and a fast path. Each line has its own configuration word. The word routes the line to one of the two paths, selects level or edge detection, and sets a 5-bit priority.

Once a path has picked a winner, the winner's line number stays frozen in that path's source register. The matching processor output stays high until software writes the matching acknowledge bit. Software reads the fast source register before the normal one, so fast requests are serviced first.

Registers are reached through a plain word-addressed bus. A read returns data one cycle after the read strobe. Only bank index 0 may route lines to the fast path.

Top module: `prio_irq_bank`

## Requirements
- R1: After reset, every mask bit is 1, pending is 0, both outputs are low and both source registers read 0.
- R2: Line i has a configuration word at byte address 4·i. Bit 0 routes the line to the fast path, bit 1 selects edge mode when 1 and level mode when 0, and bits 6:2 hold the priority. Reads return these bits with every other bit 0.
- R3: In a bank whose index parameter is not 0, the routing bit always reads 0, and every line is served on the normal path.
- R4: The mask register is at byte address 4·N (0x80). A mask bit of 1 keeps its line from taking part in selection, while the line's pending bit still latches.
- R5: The pending register is at 4·N+4 (0x84). A write ANDs each edge-mode pending bit with the written bit, so writing 0 drops every latched edge request.
- R6: An edge-mode line sets its pending bit on a rising input and keeps it after the input falls. A level-mode line's pending bit equals its input as sampled one clock earlier.
- R7: Among active lines (pending and not masked) routed to a path, the lowest priority value wins. On a tie, the lower line number wins.
- R8: The fast source register is at 4·N+8 (0x88) and the normal one at 4·N+12 (0x8C). Each reads {bit 31 = 1, bits 4:0 = line} while its path holds a winner, and reads 0 otherwise.
- R9: A held winner stays frozen until an acknowledge. Writing the control register at 4·N+16 (0x90) with bit 0 set releases the normal path, and with bit 1 set releases the fast path; 0x3 releases both. The release clears the pending bit of an edge-mode winner.
- R10: Output irq_norm_o is high exactly while the normal path holds a winner, and irq_fast_o exactly while the fast path does. The outputs are active high and rise two clocks after the input edge that makes a line active.
- R11: A line routed to the fast path never appears on the normal path, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | N | Interrupt request lines |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | AW | Byte address, word aligned |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data, valid the cycle after bus_rd_i |
| irq_norm_o | output | 1 | Normal-path request to the processor |
| irq_fast_o | output | 1 | Fast-path request to the processor |

## Verification
An input edge reaches the pending register at the next clock edge. The path winner, the processor output and the source register follow one edge later, and read data arrives one edge after the read strobe. The bench drives inputs after the falling edge and advances its behavioural model on every rising edge. It compares both outputs and the read data at every falling edge, so each result is checked in the cycle it becomes due. Directed reads are issued only after enough idle cycles have passed to cover those two register stages.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  // priority field width is fixed by the register layout
  localparam int unsigned PRIO_W = 5;

  // configuration word bit positions
  localparam int unsigned CFG_FAST_BIT = 0;
  localparam int unsigned CFG_EDGE_BIT = 1;
  localparam int unsigned CFG_PRIO_LSB = 2;

  // word offsets of the bank registers after the N configuration words
  localparam int unsigned REG_MASK     = 0;
  localparam int unsigned REG_PEND     = 1;
  localparam int unsigned REG_SRC_FAST = 2;
  localparam int unsigned REG_SRC_NORM = 3;
  localparam int unsigned REG_CTRL     = 4;

  // path indices
  localparam int unsigned PATH_NORM = 0;
  localparam int unsigned PATH_FAST = 1;
  localparam int unsigned NUM_PATHS = 2;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              edge_mode;
    logic              fast;
  } line_cfg_t;
endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
#(
  parameter int unsigned N        = 32,
  parameter int unsigned BANK_IDX = 0,
  parameter int unsigned AW       = 8,
  parameter int unsigned DW       = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [N-1:0]             fast_o,
  output logic [N-1:0]             edge_o,
  output logic [N-1:0][PRIO_W-1:0] prio_o,
  output logic [N-1:0]             mask_o,
  output logic [NUM_PATHS-1:0]     ack_o,
  output logic                     pend_wr_o
);
  localparam int unsigned WW = AW - 2;
  localparam logic [WW-1:0] IDX_MASK = WW'(N + REG_MASK);
  localparam logic [WW-1:0] IDX_PEND = WW'(N + REG_PEND);
  localparam logic [WW-1:0] IDX_CTRL = WW'(N + REG_CTRL);

  logic          wr_ok;
  logic [WW-1:0] widx;
  line_cfg_t     cfg_q [N];
  logic [N-1:0]  mask_q;

  assign wr_ok = wr_i && (addr_i[1:0] == 2'b00);
  assign widx  = addr_i[AW-1:2];

  for (genvar i = 0; i < N; i++) begin : g_line
    localparam logic [WW-1:0] MY_IDX = WW'(i);
    logic fast_wr;

    // only the first bank may route to the fast path
    if (BANK_IDX == 0) begin : g_fast_ok
      assign fast_wr = wdata_i[CFG_FAST_BIT];
    end else begin : g_fast_off
      assign fast_wr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[i] <= '0;
      end else if (wr_ok && widx == MY_IDX) begin
        cfg_q[i].fast      <= fast_wr;
        cfg_q[i].edge_mode <= wdata_i[CFG_EDGE_BIT];
        cfg_q[i].prio      <= wdata_i[CFG_PRIO_LSB +: PRIO_W];
      end
    end

    assign fast_o[i] = cfg_q[i].fast;
    assign edge_o[i] = cfg_q[i].edge_mode;
    assign prio_o[i] = cfg_q[i].prio;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (wr_ok && widx == IDX_MASK) begin
      mask_q <= wdata_i[N-1:0];
    end
  end

  assign mask_o    = mask_q;
  assign pend_wr_o = wr_ok && (widx == IDX_PEND);
  assign ack_o[PATH_NORM] = wr_ok && (widx == IDX_CTRL) && wdata_i[0];
  assign ack_o[PATH_FAST] = wr_ok && (widx == IDX_CTRL) && wdata_i[1];

  // R4: a mask write lands on the next edge
  a_r4_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && widx == IDX_MASK) |=> (mask_q == $past(wdata_i[N-1:0])));
endmodule

// File: rtl/prio_irq_pend.sv
module prio_irq_pend #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] edge_i,
  input  logic         wr_i,
  input  logic [N-1:0] keep_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] pend_q;
  logic [N-1:0] rise;
  logic [N-1:0] keep;
  logic [N-1:0] edge_nxt;

  assign rise     = irq_i & ~prev_q;
  assign keep     = wr_i ? keep_i : '1;
  assign edge_nxt = ((pend_q & keep) & ~clr_i) | rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= irq_i;
      pend_q <= (edge_nxt & edge_i) | (irq_i & ~edge_i);
    end
  end

  assign pend_o = pend_q;

  // R6: every rising edge on an edge-mode line is latched
  a_r6_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(irq_i & ~prev_q & edge_i)) == $past(irq_i & ~prev_q & edge_i)));

  // R6: level-mode lines mirror the input one cycle later
  a_r6_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(edge_i)) == ($past(irq_i) & ~$past(edge_i))));
endmodule

// File: rtl/prio_irq_path.sv
module prio_irq_path
  import prio_irq_pkg::*;
#(
  parameter int unsigned N  = 32,
  parameter int unsigned LW = $clog2(N)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N-1:0]             cand_i,
  input  logic [N-1:0][PRIO_W-1:0] prio_i,
  input  logic                     ack_i,
  output logic                     held_o,
  output logic [LW-1:0]            line_o,
  output logic [N-1:0]             clr_o
);
  logic              found;
  logic [LW-1:0]     best_l;
  logic [PRIO_W-1:0] best_p;
  logic              held_q;
  logic [LW-1:0]     line_q;

  // lowest priority value wins; strict compare keeps the lower line on ties
  always_comb begin
    found  = 1'b0;
    best_l = '0;
    best_p = '1;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (!found || prio_i[i] < best_p)) begin
        found  = 1'b1;
        best_l = LW'(i);
        best_p = prio_i[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      line_q <= '0;
    end else if (ack_i) begin
      held_q <= 1'b0;
    end else if (!held_q && found) begin
      held_q <= 1'b1;
      line_q <= best_l;
    end
  end

  always_comb begin
    clr_o = '0;
    if (ack_i && held_q) clr_o[line_q] = 1'b1;
  end

  assign held_o = held_q;
  assign line_o = line_q;

  // R9: the winner does not move until acknowledged
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !ack_i) |=> (held_q && $stable(line_q)));

  // R9: acknowledge releases the path
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> !held_o);

  // R7: the pick is always an active candidate
  a_r7_pick_active: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> cand_i[best_l]);

  // R10: an idle path with a candidate raises its output next cycle
  a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!held_q && found && !ack_i) |=> held_o);
endmodule

// File: rtl/prio_irq_bank.sv
module prio_irq_bank
  import prio_irq_pkg::*;
#(
  parameter int unsigned N        = 32,
  parameter int unsigned BANK_IDX = 0,
  parameter int unsigned AW       = 8,
  parameter int unsigned DW       = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_i,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_norm_o,
  output logic          irq_fast_o
);
  localparam int unsigned LW = $clog2(N);
  localparam int unsigned WW = AW - 2;
  localparam logic [WW-1:0] IDX_MASK     = WW'(N + REG_MASK);
  localparam logic [WW-1:0] IDX_PEND     = WW'(N + REG_PEND);
  localparam logic [WW-1:0] IDX_SRC_FAST = WW'(N + REG_SRC_FAST);
  localparam logic [WW-1:0] IDX_SRC_NORM = WW'(N + REG_SRC_NORM);

  logic [N-1:0]                  fast_v;
  logic [N-1:0]                  edge_v;
  logic [N-1:0][PRIO_W-1:0]      prio_v;
  logic [N-1:0]                  mask_v;
  logic [NUM_PATHS-1:0]          ack_v;
  logic                          pend_wr;
  logic [N-1:0]                  pend_v;
  logic [N-1:0]                  active;
  logic [NUM_PATHS-1:0][N-1:0]   cand;
  logic [NUM_PATHS-1:0]          held;
  logic [NUM_PATHS-1:0][LW-1:0]  line;
  logic [NUM_PATHS-1:0][N-1:0]   clr;
  logic [DW-1:0]                 rdata_q;
  logic [DW-1:0]                 rd_word;
  logic [WW-1:0]                 ridx;

  prio_irq_regs #(.N(N), .BANK_IDX(BANK_IDX), .AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (bus_wr_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .fast_o    (fast_v),
    .edge_o    (edge_v),
    .prio_o    (prio_v),
    .mask_o    (mask_v),
    .ack_o     (ack_v),
    .pend_wr_o (pend_wr)
  );

  prio_irq_pend #(.N(N)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_i  (irq_i),
    .edge_i (edge_v),
    .wr_i   (pend_wr),
    .keep_i (bus_wdata_i[N-1:0]),
    .clr_i  (clr[PATH_NORM] | clr[PATH_FAST]),
    .pend_o (pend_v)
  );

  assign active          = pend_v & ~mask_v;
  assign cand[PATH_NORM] = active & ~fast_v;
  assign cand[PATH_FAST] = active & fast_v;

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    prio_irq_path #(.N(N), .LW(LW)) u_path (
      .clk    (clk),
      .rst_n  (rst_n),
      .cand_i (cand[p]),
      .prio_i (prio_v),
      .ack_i  (ack_v[p]),
      .held_o (held[p]),
      .line_o (line[p]),
      .clr_o  (clr[p])
    );
  end

  assign ridx = bus_addr_i[AW-1:2];

  always_comb begin
    rd_word = '0;
    if (bus_addr_i[1:0] == 2'b00) begin
      if (ridx < WW'(N)) begin
        rd_word[CFG_FAST_BIT]                 = fast_v[ridx[LW-1:0]];
        rd_word[CFG_EDGE_BIT]                 = edge_v[ridx[LW-1:0]];
        rd_word[CFG_PRIO_LSB +: PRIO_W]       = prio_v[ridx[LW-1:0]];
      end else if (ridx == IDX_MASK) begin
        rd_word[N-1:0] = mask_v;
      end else if (ridx == IDX_PEND) begin
        rd_word[N-1:0] = pend_v;
      end else if (ridx == IDX_SRC_FAST) begin
        rd_word[DW-1]   = held[PATH_FAST];
        rd_word[LW-1:0] = held[PATH_FAST] ? line[PATH_FAST] : '0;
      end else if (ridx == IDX_SRC_NORM) begin
        rd_word[DW-1]   = held[PATH_NORM];
        rd_word[LW-1:0] = held[PATH_NORM] ? line[PATH_NORM] : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_word;
  end

  assign bus_rdata_o = rdata_q;
  assign irq_norm_o  = held[PATH_NORM];
  assign irq_fast_o  = held[PATH_FAST];

  // R3: a bank other than the first never raises the fast output
  if (BANK_IDX != 0) begin : g_nofast
    a_r3_no_fast: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_fast_o);
  end

  // R11: a newly held normal winner was routed to the normal path
  a_r11_norm_route: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_norm_o) |-> !fast_v[line[PATH_NORM]]);
endmodule

// File: tb/prio_irq_bank_bench.sv
module prio_irq_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic        norm0, fast0, norm1, fast1;

  int n_tests = 0;
  int n_fail  = 0;
  bit checking = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_bank #(.N(N), .BANK_IDX(0)) u_prio_irq_bank (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata0),
    .irq_norm_o(norm0), .irq_fast_o(fast0));

  prio_irq_bank #(.N(N), .BANK_IDX(1)) u_prio_irq_bank_b1 (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata1),
    .irq_norm_o(norm1), .irq_fast_o(fast1));

  // behavioural model of bank 0
  bit [31:0] m_pend, m_prev, m_mask, m_rdata;
  int        m_prio [N];
  bit        m_edge [N];
  bit        m_fast [N];
  bit        m_held [2];
  int        m_line [2];

  function automatic bit [31:0] m_read(input logic [7:0] a);
    bit [31:0] v = '0;
    if (a < 8'h80) begin
      v = {25'd0, 5'(m_prio[a >> 2]), m_edge[a >> 2], m_fast[a >> 2]};
    end else if (a == 8'h80) v = m_mask;
    else if (a == 8'h84) v = m_pend;
    else if (a == 8'h88) v = m_held[1] ? (32'h8000_0000 | 32'(m_line[1])) : 0;
    else if (a == 8'h8C) v = m_held[0] ? (32'h8000_0000 | 32'(m_line[0])) : 0;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_prev = 0; m_mask = '1; m_rdata = 0;
      for (int i = 0; i < N; i++) begin m_prio[i] = 0; m_edge[i] = 0; m_fast[i] = 0; end
      for (int p = 0; p < 2; p++) begin m_held[p] = 0; m_line[p] = 0; end
    end else begin
      bit        ack [2];
      bit        found [2];
      int        best [2];
      bit [31:0] np;
      if (rd) m_rdata = m_read(addr);
      for (int p = 0; p < 2; p++) begin
        ack[p] = wr && addr == 8'h90 && wdata[p];
        found[p] = 0; best[p] = 0;
        if (!m_held[p] && !ack[p]) begin
          for (int i = 0; i < N; i++) begin
            if (m_pend[i] && !m_mask[i] && (m_fast[i] == (p == 1)) &&
                (!found[p] || m_prio[i] < m_prio[best[p]])) begin
              found[p] = 1; best[p] = i;
            end
          end
        end
      end
      for (int i = 0; i < N; i++) begin
        if (m_edge[i]) begin
          np[i] = m_pend[i];
          if (wr && addr == 8'h84) np[i] = np[i] & wdata[i];
          for (int p = 0; p < 2; p++)
            if (ack[p] && m_held[p] && m_line[p] == i) np[i] = 0;
          if (irq[i] && !m_prev[i]) np[i] = 1;
        end else begin
          np[i] = irq[i];
        end
      end
      m_pend = np;
      m_prev = irq;
      for (int p = 0; p < 2; p++) begin
        if (ack[p]) m_held[p] = 0;
        else if (found[p]) begin m_held[p] = 1; m_line[p] = best[p]; end
      end
      if (wr && addr < 8'h80 && addr[1:0] == 0) begin
        m_fast[addr >> 2] = wdata[0];
        m_edge[addr >> 2] = wdata[1];
        m_prio[addr >> 2] = int'(wdata[6:2]);
      end
      if (wr && addr == 8'h80) m_mask = wdata;
    end
  end

  task automatic check(input bit [31:0] act, input bit [31:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // model comparison on every falling edge
  always @(negedge clk) begin
    if (rst_n && checking) begin
      check(32'(norm0), 32'(m_held[0]), "R10 irq_norm_o vs model");
      check(32'(fast0), 32'(m_held[1]), "R10 irq_fast_o vs model");
      check(rdata0, m_rdata, "R8 read data vs model");
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0; wdata = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d0, output logic [31:0] d1);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); rd = 0; d0 = rdata0; d1 = rdata1;
  endtask

  task automatic pulse(input logic [31:0] m);
    @(negedge clk); irq = irq | m;
    @(negedge clk); irq = irq & ~m;
  endtask

  initial begin
    logic [31:0] d0, d1;
    idle(3);
    rst_n = 1;
    checking = 1;
    idle(1);
    // reset state
    check(32'(norm0), 0, "R1 normal output after reset");
    check(32'(fast0), 0, "R1 fast output after reset");
    bus_read(8'h80, d0, d1); check(d0, 32'hFFFF_FFFF, "R1 R4 mask after reset");
    bus_read(8'h8C, d0, d1); check(d0, 0, "R1 R8 normal source idle");
    bus_read(8'h84, d0, d1); check(d0, 0, "R1 pending after reset");

    // configuration words
    bus_write(8'h14, 32'h0000_000E);   // line 5: prio 3, edge, normal
    bus_write(8'h24, 32'h0000_000F);   // line 9: prio 3, edge, fast
    bus_write(8'h30, 32'h0000_0004);   // line 12: prio 1, level, normal
    bus_write(8'h50, 32'h0000_000E);   // line 20: prio 3, edge, normal
    bus_read(8'h14, d0, d1); check(d0, 32'h0000_000E, "R2 line 5 word");
    bus_read(8'h24, d0, d1);
    check(d0, 32'h0000_000F, "R2 line 9 word bank 0");
    check(d1, 32'h0000_000E, "R3 fast bit forced low in bank 1");
    bus_write(8'h80, 32'h0);

    // tie on priority, edge latching
    pulse(32'h0010_0020);
    idle(2);
    check(32'(norm0), 1, "R10 normal output raised");
    bus_read(8'h8C, d0, d1); check(d0, 32'h8000_0005, "R7 tie goes to lower line");
    bus_read(8'h84, d0, d1); check(d0, 32'h0010_0020, "R6 edges kept after input fell");

    // better priority arrives while frozen
    @(negedge clk); irq[12] = 1;
    idle(3);
    bus_read(8'h8C, d0, d1); check(d0, 32'h8000_0005, "R9 winner frozen");
    bus_write(8'h90, 32'h1);
    idle(2);
    bus_read(8'h8C, d0, d1); check(d0, 32'h8000_000C, "R7 lower priority value wins");
    bus_read(8'h84, d0, d1); check(d0, 32'h0010_1000, "R9 ack cleared edge winner");

    // level line drops
    @(negedge clk); irq[12] = 0;
    idle(2);
    bus_read(8'h84, d0, d1); check(d0, 32'h0010_0000, "R6 level pending follows input");
    bus_write(8'h90, 32'h1);
    idle(2);
    bus_read(8'h8C, d0, d1); check(d0, 32'h8000_0014, "R9 next winner after ack");
    bus_write(8'h90, 32'h1);
    idle(2);
    check(32'(norm0), 0, "R10 normal output low with nothing active");

    // masking and pending clear
    bus_write(8'h80, 32'h0000_0020);
    pulse(32'h0000_0020);
    idle(3);
    check(32'(norm0), 0, "R4 masked line does not interrupt");
    bus_read(8'h84, d0, d1); check(d0, 32'h0000_0020, "R4 masked line still pending");
    bus_write(8'h84, 32'h0);
    bus_read(8'h84, d0, d1); check(d0, 0, "R5 pending write of zero clears");
    bus_write(8'h80, 32'h0);
    idle(3);
    check(32'(norm0), 0, "R5 cleared request gone after unmask");

    // fast path and routing
    pulse(32'h0000_0200);
    idle(2);
    check(32'(fast0), 1, "R10 fast output raised");
    check(32'(norm0), 0, "R11 fast line absent from normal path");
    check(32'(fast1), 0, "R3 bank 1 fast output stays low");
    check(32'(norm1), 1, "R3 bank 1 serves line on normal path");
    bus_read(8'h88, d0, d1);
    check(d0, 32'h8000_0009, "R8 fast source register");
    check(d1, 0, "R3 bank 1 fast source empty");
    bus_read(8'h8C, d0, d1);
    check(d0, 0, "R11 normal source empty in bank 0");
    check(d1, 32'h8000_0009, "R3 bank 1 normal source");
    bus_write(8'h90, 32'h3);
    idle(2);
    check(32'(fast0), 0, "R9 fast ack releases path");
    check(32'(norm1), 0, "R9 combined ack releases bank 1");
    bus_read(8'h84, d0, d1); check(d0, 0, "R9 fast edge winner cleared");
    idle(3);

    checking = 0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule